// File: doc/BRIEF.md
# Per-Pin GPIO Controller with Interrupt Detection

This block controls a bank of general-purpose pins through a simple word-addressed register bus. Every pin owns one 32-bit configuration word. That word packs the output value, a read-back of the synchronized pin level, a 3-bit mode, a 2-bit alternate-function select, an input-enable bit and an interrupt-group selector. The mode picks one of three behaviours for the pin: plain input, driven output, or one of several interrupt triggers. The triggers are high level, low level, rising edge, falling edge and either edge. A last mode value turns interrupts off.

Pin inputs pass through a two-flop synchronizer. Edges are found by comparing the synchronized sample with the sample one cycle older. Detected events set sticky bits in status words, one bit per pin and 32 pins per word. Software clears a bit by writing 1 to it. A new event in the same cycle as the clear wins, so an event that arrives after software has read a word is not lost. A single interrupt output is high while any status bit is pending.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: After reset every configuration word reads with bits 31:1 zero, all status words read 0, and pin_oe, pin_out and irq are all 0.
- R2: The configuration word of pin N sits at byte address N*4. Bits 3:1 (mode), 6:5 (function), 9 (input enable) and 18:16 (group) read back as last written. All other bits except bit 0 read 0.
- R3: Writing bit 0 of a pin's word sets that pin's pin_out. Reading bit 0 returns the pin input level, two clock edges after it changes.
- R4: pin_oe of a pin is 1 exactly when its mode field is 1.
- R5: Mode 2 sets the pin's status bit on each cycle the synchronized input is 1. Mode 3 does the same while the input is 0. While the level persists, the bit stays set even right after a clear.
- R6: Mode 4 sets the status bit on a 0-to-1 input change, mode 5 on a 1-to-0 change, and mode 6 on either change. A steady input sets nothing.
- R7: Modes 0, 1 and 7 never set a status bit. A nonzero group field (bits 18:16) also blocks every status set.
- R8: The status word for pins 32k..32k+31 is at byte address 0x800 + 4k, with pin 32k+j at bit j. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: If a new event and a write-1 clear hit the same status bit in the same cycle, the bit stays set.
- R10: irq is 1 exactly while at least one status bit is set.
- R11: Reads of addresses that map to no pin and no status word return 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address (low two bits ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pin_in | input | NUM_PINS (64) | Asynchronous pin levels |
| pin_out | output | NUM_PINS (64) | Output values |
| pin_oe | output | NUM_PINS (64) | Output enables |
| irq | output | 1 | Interrupt request, high while any status bit pends |

## Verification
Each trigger mode is driven with all four two-sample input histories: low-low, low-high, high-low and high-high. This separates level from edge detection and rising from falling. Random rounds pick a pin in either status word, a trigger mode and a starting and final level, so the word address and bit position are checked along with the mode. Directed cases cover the points where status logic usually breaks: a clear that lands in the same cycle as a new edge, a clear while a level is still asserted, and a write of 0. Further cases show that a nonzero group field or a non-interrupt mode blocks detection even when the input toggles.

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl #(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);
  localparam int WA        = ADDR_W - 2;
  localparam int PIN_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam int NUM_WORDS = (NUM_PINS + 31) / 32;
  localparam int SW        = NUM_WORDS * 32;
  localparam logic [WA-1:0] STAT_WORD = WA'(12'h800 >> 2);
  localparam logic [WA-1:0] PIN_LIM   = WA'(NUM_PINS);
  localparam logic [WA-1:0] WORD_LIM  = WA'(NUM_WORDS);

  logic [NUM_PINS-1:0] cfg_data, cfg_ien;
  logic [2:0]          cfg_mode [NUM_PINS];
  logic [1:0]          cfg_func [NUM_PINS];
  logic [2:0]          cfg_grp  [NUM_PINS];
  logic [NUM_PINS-1:0] s1, s2, prev;
  logic [NUM_PINS-1:0] stat_q, set_v, clr_v;
  logic [SW-1:0]       stat_view;

  logic [WA-1:0]    word_idx, sw_idx;
  logic [PIN_W-1:0] pin_idx;
  logic             wr, cfg_hit, stat_hit;

  assign word_idx = bus_addr[ADDR_W-1:2];
  assign pin_idx  = word_idx[PIN_W-1:0];
  assign sw_idx   = word_idx - STAT_WORD;
  assign wr       = bus_sel & bus_we;
  assign cfg_hit  = (word_idx < STAT_WORD) && (word_idx < PIN_LIM);
  assign stat_hit = (word_idx >= STAT_WORD) && (sw_idx < WORD_LIM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; prev <= '0;
    end else begin
      s1 <= pin_in; s2 <= s1; prev <= s2;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_PINS; i++) begin
      if (!rst_n) begin
        cfg_data[i] <= 1'b0;
        cfg_ien[i]  <= 1'b0;
        cfg_mode[i] <= 3'd0;
        cfg_func[i] <= 2'd0;
        cfg_grp[i]  <= 3'd0;
      end else if (wr && cfg_hit && pin_idx == PIN_W'(i)) begin
        cfg_data[i] <= bus_wdata[0];
        cfg_mode[i] <= bus_wdata[3:1];
        cfg_func[i] <= bus_wdata[6:5];
        cfg_ien[i]  <= bus_wdata[9];
        cfg_grp[i]  <= bus_wdata[18:16];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      case (cfg_mode[i])
        3'd2:    set_v[i] = s2[i];
        3'd3:    set_v[i] = ~s2[i];
        3'd4:    set_v[i] = s2[i] & ~prev[i];
        3'd5:    set_v[i] = ~s2[i] & prev[i];
        3'd6:    set_v[i] = s2[i] ^ prev[i];
        default: set_v[i] = 1'b0;
      endcase
      if (cfg_grp[i] != 3'd0) set_v[i] = 1'b0;
      clr_v[i] = wr && stat_hit && (sw_idx == WA'(i / 32)) && bus_wdata[i % 32];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_v) | set_v;
  end

  generate
    if (SW > NUM_PINS) begin : g_pad
      assign stat_view = {{(SW - NUM_PINS){1'b0}}, stat_q};
    end else begin : g_nopad
      assign stat_view = stat_q;
    end
  endgenerate

  always_comb begin
    bus_rdata = 32'd0;
    if (cfg_hit)
      bus_rdata = {13'd0, cfg_grp[pin_idx], 6'd0, cfg_ien[pin_idx], 2'd0,
                   cfg_func[pin_idx], 1'b0, cfg_mode[pin_idx], s2[pin_idx]};
    else if (stat_hit)
      bus_rdata = stat_view[32 * int'(sw_idx) +: 32];
  end

  always_comb
    for (int i = 0; i < NUM_PINS; i++) pin_oe[i] = (cfg_mode[i] == 3'd1);

  assign pin_out = cfg_data;
  assign irq     = |stat_q;
endmodule

// File: rtl/gpio_pin_ctrl_chk.sv
module gpio_pin_ctrl_chk #(
  parameter int NUM_PINS = 64,
  parameter int ADDR_W   = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [31:0]         bus_wdata,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic                irq,
  input logic                stat0,
  input logic [2:0]          mode0
);
  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq && pin_oe == '0)); // R1

  AST_OE_NOT_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == '0 && bus_wdata[3:1] != 3'd1) |=> !pin_oe[0]); // R4

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat0 && !(bus_sel && bus_we && bus_addr == ADDR_W'(12'h800) && bus_wdata[0])) |=> stat0); // R8

  AST_QUIET_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat0 && (mode0 == 3'd0 || mode0 == 3'd1 || mode0 == 3'd7)) |=> !stat0); // R7
endmodule

bind gpio_pin_ctrl gpio_pin_ctrl_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .pin_oe(pin_oe), .irq(irq),
  .stat0(stat_q[0]), .mode0(cfg_mode[0])
);

// File: tb/gpio_pin_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_pin_ctrl_bench;
  localparam int NP = 64;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NP-1:0] pin_in = '0, pin_out, pin_oe;
  logic irq;
  int nvec = 0, nfail = 0;

  gpio_pin_ctrl #(.NUM_PINS(NP), .ADDR_W(12)) u_gpio_pin_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; bus_sel = 1'b1; bus_we = 1'b0;
    #0.5 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [11:0] st_addr(input int p);
    return 12'h800 + 12'(4 * (p / 32));
  endfunction

  function automatic logic exp_stat(input logic [2:0] m, input logic l0, input logic l1);
    case (m)
      3'd2: return l0 | l1;
      3'd3: return ~l0 | ~l1;
      3'd4: return ~l0 & l1;
      3'd5: return l0 & ~l1;
      3'd6: return l0 ^ l1;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(12'h000, d); chk("R1 cfg pin0", d, 32'h0);
    rd(12'h0FC, d); chk("R1 cfg pin63", d, 32'h0);
    rd(12'h800, d); chk("R1 status w0", d, 32'h0);
    rd(12'h804, d); chk("R1 status w1", d, 32'h0);
    chk("R1 irq/oe/out", {31'd0, irq | (|pin_oe) | (|pin_out)}, 32'h0);

    wr(12'h00C, 32'hFFFF_FFFF);
    rd(12'h00C, d); chk("R2 cfg pin3 fields", d, 32'h0007_026E);
    wr(12'h0FC, 32'h0001_0044);
    rd(12'h0FC, d); chk("R2 cfg pin63 fields", d, 32'h0001_0044);
    wr(12'h00C, 32'h0);
    wr(12'h0FC, 32'h0);

    wr(12'h01C, 32'h3);
    chk("R4 oe in output mode", {31'd0, pin_oe[7]}, 32'h1);
    chk("R3 pin_out follows data", {31'd0, pin_out[7]}, 32'h1);
    wr(12'h01C, 32'h1);
    chk("R4 oe off in input mode", {31'd0, pin_oe[7]}, 32'h0);
    chk("R3 data kept in input mode", {31'd0, pin_out[7]}, 32'h1);
    wr(12'h01C, 32'h0);

    @(negedge clk); pin_in[9] = 1'b1;
    @(negedge clk); rd(12'h024, d); chk("R3 level not yet visible", d, 32'h0);
    @(negedge clk); rd(12'h024, d); chk("R3 level read back", d, 32'h1);

    wr(12'h008, 32'h8);
    settle();
    rd(12'h800, d); chk("R6 steady input no event", d, 32'h0);
    @(negedge clk); pin_in[2] = 1'b1;
    settle();
    rd(12'h800, d); chk("R6 rise sets bit2", d, 32'h4);
    chk("R10 irq while pending", {31'd0, irq}, 32'h1);
    wr(12'h800, 32'h0);
    rd(12'h800, d); chk("R8 write 0 keeps", d, 32'h4);
    wr(12'h800, 32'h4);
    rd(12'h800, d); chk("R8 write 1 clears", d, 32'h0);
    chk("R10 irq drops", {31'd0, irq}, 32'h0);
    @(negedge clk); pin_in[2] = 1'b0;
    settle();
    rd(12'h800, d); chk("R6 fall ignored in rise mode", d, 32'h0);

    @(negedge clk); pin_in[2] = 1'b1;
    settle();
    @(negedge clk); pin_in[2] = 1'b0;
    settle();
    @(negedge clk); pin_in[2] = 1'b1;
    @(negedge clk);
    wr(12'h800, 32'h4);
    rd(12'h800, d); chk("R9 edge same cycle as clear stays", d, 32'h4);
    wr(12'h800, 32'h4);
    rd(12'h800, d); chk("R9 later clear works", d, 32'h0);
    wr(12'h008, 32'h0);

    @(negedge clk); pin_in[33] = 1'b1;
    wr(12'h084, 32'hA);
    settle();
    wr(12'h804, 32'hFFFF_FFFF);
    @(negedge clk); pin_in[33] = 1'b0;
    settle();
    rd(12'h804, d); chk("R8 R6 fall pin33 in word1 bit1", d, 32'h2);
    rd(12'h800, d); chk("R8 word0 untouched", d, 32'h0);
    wr(12'h804, 32'h2);
    wr(12'h084, 32'h0);

    wr(12'h010, 32'h4);
    @(negedge clk); pin_in[4] = 1'b1;
    settle();
    wr(12'h800, 32'h10);
    rd(12'h800, d); chk("R5 high level re-sets after clear", d, 32'h10);
    @(negedge clk); pin_in[4] = 1'b0;
    settle();
    wr(12'h800, 32'h10);
    rd(12'h800, d); chk("R5 cleared once level gone", d, 32'h0);
    wr(12'h010, 32'h6);
    settle();
    rd(12'h800, d); chk("R5 low level sets", d, 32'h10);
    wr(12'h010, 32'h0);
    wr(12'h800, 32'h10);

    wr(12'h018, 32'h0001_0008);
    @(negedge clk); pin_in[6] = 1'b1;
    settle();
    rd(12'h800, d); chk("R7 nonzero group blocks", d, 32'h0);
    wr(12'h018, 32'hE);
    @(negedge clk); pin_in[6] = 1'b0;
    settle();
    @(negedge clk); pin_in[6] = 1'b1;
    settle();
    rd(12'h800, d); chk("R7 mode 7 blocks", d, 32'h0);
    chk("R10 irq idle", {31'd0, irq}, 32'h0);
    wr(12'h018, 32'h0);

    rd(12'h100, d); chk("R11 beyond last pin reads 0", d, 32'h0);
    rd(12'h808, d); chk("R11 missing status word reads 0", d, 32'h0);
    rd(12'h840, d); chk("R11 other group reads 0", d, 32'h0);
    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h100, d); chk("R11 write beyond last pin ignored", d, 32'h0);
    rd(12'h000, d); chk("R11 pin0 untouched by stray write", d, 32'h0);

    for (int k = 0; k < 40; k++) begin
      int p;
      logic [2:0] m;
      logic l0, l1;
      p  = int'($urandom % NP);
      m  = 3'(2 + ($urandom % 5));
      l0 = 1'($urandom);
      l1 = 1'($urandom);
      if (p == 9) p = 10;
      @(negedge clk); pin_in[p] = l0;
      wr(12'(4 * p), {28'd0, m, 1'b0});
      settle();
      wr(st_addr(p), 32'(1) << (p % 32));
      @(negedge clk); pin_in[p] = l1;
      settle();
      rd(st_addr(p), d);
      chk($sformatf("R5 R6 random pin%0d mode%0d %0d->%0d", p, m, l0, l1),
          {31'd0, d[p % 32]}, {31'd0, exp_stat(m, l0, l1)});
      rd(12'(4 * p), d);
      chk("R3 random readback", {31'd0, d[0]}, {31'd0, l1});
      wr(12'(4 * p), 32'h0);
      wr(st_addr(p), 32'(1) << (p % 32));
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule